// File: doc/BRIEF.md
# Single-Channel Bus-Mastering Block Mover

This block copies a run of bytes from one address range to another while the processor is off the bus. Software loads a source address, a destination address, a byte count, a release policy and a cycle type, then pulses `start`. The block takes the shared bus from the current owner through a single open-drain request/grant line. It moves the bytes and hands the bus back on the same line.

Three release policies set how long it keeps the bus. Per-byte hands the bus back after every byte. Demand-paced keeps the bus while the peripheral stays ready. Whole-block keeps the bus until the count is exhausted. Two cycle types are offered. Two-step fetches a byte into an internal holding register and then stores it. Fly-by raises both strobes at once, so the data goes straight from the source to the sink and never enters the block.

The line is modelled as a sampled input `rqgt_in` plus an active-low pull-down enable `rqgt_oe_n`. The wire outside the block is the AND of every pull-down.

Top module: `dma_xfer_ctrl`

## Requirements
- R1: While `rst_n` is low, `rqgt_oe_n` is 1, and `bus_oe`, `rd_stb`, `wr_stb` and `done` are 0.
- R2: When a start is accepted with a non-zero count and `periph_rdy` is 1, the block pulls the line low for exactly one clock. It then keeps `bus_oe` at 0 until it samples the line low again, which is the grant.
- R3: When the grant is sampled low at rising edge G, `bus_oe` first reads 1 after edge G + `float_dly`.
- R4: To give the bus back, the block holds `bus_oe` and both strobes at 0 for one clock. In the next clock it pulls the line low for exactly one clock, the release. It never pulls the line while `bus_oe` is 1.
- R5: With `flyby`=0, each byte takes two clocks. First, one clock of `rd_stb` alone with `bus_addr` = source address, and the byte on `rd_data` is captured at the end of that clock. Then one clock of `wr_stb` alone with `bus_addr` = destination address and `wr_data` = the captured byte.
- R6: With `flyby`=1, each byte takes one clock in which `rd_stb` and `wr_stb` are both 1 and `bus_addr` = source address.
- R7: Byte i (counting from 0) uses source address + i and destination address + i, modulo 2^AW. Exactly `byte_count` bytes are moved, and the count never goes below zero.
- R8: Per-byte policy (`mode_sel`=0): exactly one byte is moved per bus tenure, so the number of requests equals the count.
- R9: Demand-paced policy (`mode_sel`=1): the bus is kept while `periph_rdy` is 1. If `periph_rdy` is 0 when the next byte is due, the bus is given back, and it is requested again once `periph_rdy` returns to 1.
- R10: Whole-block policy (`mode_sel`=2 or 3): one tenure covers the whole count. If `periph_rdy` is 0, the block waits with the bus held and no strobe.
- R11: `done` rises one clock after the final release and stays 1 until the next accepted start, which clears it. A start with count 0 sets `done` at the next edge, with no request.
- R12: A start pulsed while a transfer is in progress is ignored. The addresses and count already latched are unaffected.

Parameters: AW = 16, CW = 8, DATA_W = 8, DW = 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start command, taken only while idle |
| src_addr | input | AW | First source address |
| dst_addr | input | AW | First destination address |
| byte_count | input | CW | Number of bytes to move |
| mode_sel | input | 2 | Release policy: 0 per-byte, 1 demand-paced, 2/3 whole-block |
| flyby | input | 1 | 1 selects fly-by cycles, 0 selects two-step cycles |
| float_dly | input | DW | Clocks to wait after the grant before driving the bus |
| periph_rdy | input | 1 | Peripheral can supply or accept data |
| rd_data | input | DATA_W | Read data bus |
| rqgt_in | input | 1 | Sampled level of the shared request/grant line |
| rqgt_oe_n | output | 1 | Active-low pull-down enable for the shared line |
| bus_oe | output | 1 | Block is driving the bus |
| bus_addr | output | AW | Address bus |
| rd_stb | output | 1 | Read strobe |
| wr_stb | output | 1 | Write strobe |
| wr_data | output | DATA_W | Write data (captured byte during a two-step write) |
| done | output | 1 | Transfer complete |

## Verification
The assertions rest on the following assumptions about the environment:
- The shared line is never low in the clock right after the block's own request pulse.
- A grant is a single one-clock low pulse that is sent only after a request.
- Nobody else pulls the line while the block owns the bus.
- `periph_rdy` and the configuration inputs are stable around the edges where they are sampled.

The bench's arbiter model keeps to these assumptions:
- It waits two clocks after seeing the request before it grants.
- It pulls the line for exactly one clock per grant.
- After a grant it watches only for the block's release.
- All stimulus, including the ready pattern, changes on the falling edge.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [1:0] {
        XM_SINGLE = 2'd0,
        XM_DEMAND = 2'd1,
        XM_BLOCK  = 2'd2
    } xfer_mode_e;

    typedef enum logic [2:0] {
        LK_IDLE,
        LK_REQ,
        LK_WAIT,
        LK_FLOAT,
        LK_OWN,
        LK_DROP,
        LK_REL
    } link_state_e;

    typedef enum logic [2:0] {
        EN_IDLE,
        EN_ARM,
        EN_WAITOWN,
        EN_SERVE,
        EN_RD,
        EN_WR,
        EN_FLY,
        EN_GIVE
    } eng_state_e;

    function automatic xfer_mode_e decode_mode(input logic [1:0] sel);
        case (sel)
            2'd0:    return XM_SINGLE;
            2'd1:    return XM_DEMAND;
            default: return XM_BLOCK;
        endcase
    endfunction

endpackage

// File: rtl/dma_bus_link.sv
module dma_bus_link
    import dma_pkg::*;
#(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          want_bus,
    input  logic          give_back,
    input  logic          line_in,
    input  logic [DW-1:0] float_dly,
    output logic          line_oe_n,
    output logic          owned,
    output logic          rel_pulse
);

    typedef struct packed {
        link_state_e   st;
        logic [DW-1:0] wait_cnt;
    } link_t;

    link_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        case (cur_q.st)
            LK_IDLE: begin
                if (want_bus) nxt_d.st = LK_REQ;
            end
            LK_REQ: begin
                nxt_d.st = LK_WAIT;
            end
            LK_WAIT: begin
                if (!line_in) begin
                    if (float_dly == '0) begin
                        nxt_d.st = LK_OWN;
                    end else begin
                        nxt_d.st       = LK_FLOAT;
                        nxt_d.wait_cnt = float_dly - DW'(1);
                    end
                end
            end
            LK_FLOAT: begin
                if (cur_q.wait_cnt == '0) nxt_d.st = LK_OWN;
                else nxt_d.wait_cnt = cur_q.wait_cnt - DW'(1);
            end
            LK_OWN: begin
                if (give_back) nxt_d.st = LK_DROP;
            end
            LK_DROP: begin
                nxt_d.st = LK_REL;
            end
            LK_REL: begin
                nxt_d.st = LK_IDLE;
            end
            default: nxt_d.st = LK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.st       <= LK_IDLE;
            cur_q.wait_cnt <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign line_oe_n = !((cur_q.st == LK_REQ) || (cur_q.st == LK_REL));
    assign owned     = (cur_q.st == LK_OWN);
    assign rel_pulse = (cur_q.st == LK_REL);

    // R2: request and release pulses last one clock
    p_pulse_one_clk_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line_oe_n) |=> line_oe_n);

    // R3: a non-zero float delay keeps the bus undriven after the grant
    p_float_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == LK_WAIT && !line_in && float_dly != '0) |=> !owned);

    // R4: the release follows one idle clock after dropping the bus
    p_release_after_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(owned) |=> !line_oe_n);

    // R4: never pull the shared line while driving the bus
    p_no_pull_while_owned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(owned && !line_oe_n));

endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
    import dma_pkg::*;
#(
    parameter int AW     = 16,
    parameter int CW     = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [AW-1:0]     src_in,
    input  logic [AW-1:0]     dst_in,
    input  logic [CW-1:0]     cnt_in,
    input  logic [1:0]        mode_in,
    input  logic              flyby_in,
    input  logic              periph_rdy,
    input  logic              owned,
    input  logic              rel_pulse,
    input  logic [DATA_W-1:0] rd_data,
    output logic              want_bus,
    output logic              give_back,
    output logic [AW-1:0]     addr,
    output logic              rd_stb,
    output logic              wr_stb,
    output logic [DATA_W-1:0] wr_data,
    output logic              done
);

    typedef struct packed {
        eng_state_e        st;
        logic [AW-1:0]     src;
        logic [AW-1:0]     dst;
        logic [CW-1:0]     left;
        xfer_mode_e        mode;
        logic              fly;
        logic [DATA_W-1:0] hold;
        logic              done;
    } eng_t;

    eng_t cur_q, nxt_d;

    always_comb begin
        nxt_d     = cur_q;
        want_bus  = 1'b0;
        give_back = 1'b0;
        rd_stb    = 1'b0;
        wr_stb    = 1'b0;
        addr      = '0;
        wr_data   = '0;
        case (cur_q.st)
            EN_IDLE: begin
                if (start) begin
                    nxt_d.src  = src_in;
                    nxt_d.dst  = dst_in;
                    nxt_d.left = cnt_in;
                    nxt_d.mode = decode_mode(mode_in);
                    nxt_d.fly  = flyby_in;
                    nxt_d.done = (cnt_in == '0);
                    nxt_d.st   = (cnt_in == '0) ? EN_IDLE : EN_ARM;
                end
            end
            EN_ARM: begin
                want_bus = periph_rdy;
                if (periph_rdy) nxt_d.st = EN_WAITOWN;
            end
            EN_WAITOWN: begin
                if (owned) nxt_d.st = EN_SERVE;
            end
            EN_SERVE: begin
                if (cur_q.mode == XM_DEMAND && !periph_rdy) begin
                    nxt_d.st = EN_GIVE;
                end else if (periph_rdy) begin
                    nxt_d.st = cur_q.fly ? EN_FLY : EN_RD;
                end
            end
            EN_RD: begin
                rd_stb     = 1'b1;
                addr       = cur_q.src;
                nxt_d.hold = rd_data;
                nxt_d.st   = EN_WR;
            end
            EN_WR, EN_FLY: begin
                if (cur_q.st == EN_WR) begin
                    wr_stb  = 1'b1;
                    addr    = cur_q.dst;
                    wr_data = cur_q.hold;
                end else begin
                    rd_stb = 1'b1;
                    wr_stb = 1'b1;
                    addr   = cur_q.src;
                end
                nxt_d.src  = cur_q.src + AW'(1);
                nxt_d.dst  = cur_q.dst + AW'(1);
                nxt_d.left = cur_q.left - CW'(1);
                nxt_d.st   = (cur_q.mode == XM_SINGLE || cur_q.left == CW'(1))
                             ? EN_GIVE : EN_SERVE;
            end
            EN_GIVE: begin
                give_back = 1'b1;
                if (rel_pulse) begin
                    if (cur_q.left == '0) begin
                        nxt_d.st   = EN_IDLE;
                        nxt_d.done = 1'b1;
                    end else begin
                        nxt_d.st = EN_ARM;
                    end
                end
            end
            default: nxt_d.st = EN_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.st   <= EN_IDLE;
            cur_q.src  <= '0;
            cur_q.dst  <= '0;
            cur_q.left <= '0;
            cur_q.mode <= XM_SINGLE;
            cur_q.fly  <= 1'b0;
            cur_q.hold <= '0;
            cur_q.done <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign done = cur_q.done;

    // R5: strobes only while the bus is owned
    p_strobe_needs_bus_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb || wr_stb) |-> owned);

    // R5: a lone read is followed by a lone write
    p_read_then_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !wr_stb) |=> (wr_stb && !rd_stb));

    // R7: no transfer with an exhausted count
    p_count_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb) |-> (cur_q.left != '0));

    // R8: per-byte policy hands back after each byte
    p_single_gives_back_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && cur_q.mode == XM_SINGLE) |=> give_back);

    // R10: whole-block policy keeps the bus while bytes remain
    p_block_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == EN_SERVE && cur_q.mode == XM_BLOCK) |=> owned);

    // R11: an accepted start with a non-zero count clears done
    p_start_clears_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (start && cur_q.st == EN_IDLE && cnt_in != '0) |=> !done);

    // R12: start while waiting for the bus changes nothing latched
    p_ignored_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (start && cur_q.st == EN_ARM) |=>
            (cur_q.src == $past(cur_q.src) && cur_q.left == $past(cur_q.left)));

endmodule

// File: rtl/dma_xfer_ctrl.sv
module dma_xfer_ctrl
    import dma_pkg::*;
#(
    parameter int AW     = 16,
    parameter int CW     = 8,
    parameter int DATA_W = 8,
    parameter int DW     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [AW-1:0]     src_addr,
    input  logic [AW-1:0]     dst_addr,
    input  logic [CW-1:0]     byte_count,
    input  logic [1:0]        mode_sel,
    input  logic              flyby,
    input  logic [DW-1:0]     float_dly,
    input  logic              periph_rdy,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              rqgt_in,
    output logic              rqgt_oe_n,
    output logic              bus_oe,
    output logic [AW-1:0]     bus_addr,
    output logic              rd_stb,
    output logic              wr_stb,
    output logic [DATA_W-1:0] wr_data,
    output logic              done
);

    logic want_bus;
    logic give_back;
    logic owned;
    logic rel_pulse;

    dma_bus_link #(.DW(DW)) u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .want_bus  (want_bus),
        .give_back (give_back),
        .line_in   (rqgt_in),
        .float_dly (float_dly),
        .line_oe_n (rqgt_oe_n),
        .owned     (owned),
        .rel_pulse (rel_pulse)
    );

    dma_xfer_engine #(.AW(AW), .CW(CW), .DATA_W(DATA_W)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .src_in     (src_addr),
        .dst_in     (dst_addr),
        .cnt_in     (byte_count),
        .mode_in    (mode_sel),
        .flyby_in   (flyby),
        .periph_rdy (periph_rdy),
        .owned      (owned),
        .rel_pulse  (rel_pulse),
        .rd_data    (rd_data),
        .want_bus   (want_bus),
        .give_back  (give_back),
        .addr       (bus_addr),
        .rd_stb     (rd_stb),
        .wr_stb     (wr_stb),
        .wr_data    (wr_data),
        .done       (done)
    );

    assign bus_oe = owned;

    // R1: nothing is driven while reset is held
    always_comb begin
        if (!rst_n) begin
            p_reset_quiet_r1: assert (rqgt_oe_n && !bus_oe && !done);
        end
    end

endmodule

// File: tb/sim_dma_xfer_ctrl.sv
`timescale 1ns/1ps
module sim_dma_xfer_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] src_addr = '0;
    logic [15:0] dst_addr = '0;
    logic [7:0]  byte_count = '0;
    logic [1:0]  mode_sel = '0;
    logic        flyby = 1'b0;
    logic [3:0]  float_dly = '0;
    logic        periph_rdy = 1'b1;
    logic        pull_n = 1'b1;
    logic [7:0]  rd_data;
    logic        rqgt_in;
    logic        rqgt_oe_n, bus_oe, rd_stb, wr_stb, done;
    logic [15:0] bus_addr;
    logic [7:0]  wr_data;

    always #2 clk = ~clk;

    assign rqgt_in = rqgt_oe_n & pull_n;
    assign rd_data = bus_addr[7:0] ^ 8'hA5;

    dma_xfer_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .src_addr(src_addr),
        .dst_addr(dst_addr), .byte_count(byte_count), .mode_sel(mode_sel),
        .flyby(flyby), .float_dly(float_dly), .periph_rdy(periph_rdy),
        .rd_data(rd_data), .rqgt_in(rqgt_in), .rqgt_oe_n(rqgt_oe_n),
        .bus_oe(bus_oe), .bus_addr(bus_addr), .rd_stb(rd_stb),
        .wr_stb(wr_stb), .wr_data(wr_data), .done(done)
    );

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit finished = 0;
    int c_mode = 0, c_fly = 0, c_dly = 0, c_cnt = 0, c_k = 3;
    logic [15:0] c_src = '0, c_dst = '0;
    int reqs = 0, rels = 0, exp_idx = 0, ten_bytes = 0;
    int arb_st = 0, arb_gap = 0, grant_cyc = 0, last_rel_cyc = 0, rdy_timer = 0;
    bit chk_req = 0, prev_oe = 0, prev2_oe = 0, prev_rd = 0, done_prev = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    initial forever @(posedge clk) cyc++;

    // arbiter model, byte monitor and ready pattern, all on the falling edge
    initial forever @(negedge clk) begin
        logic [15:0] ea;
        if (rst_n) begin
            if (!pull_n) pull_n = 1'b1;
            // R10: the bus stays held during a stall
            if (c_mode == 2 && !periph_rdy && exp_idx > 0 && exp_idx < c_cnt)
                chk(bus_oe, "R10", "bus held while stalled", bus_oe, 1);
            case (arb_st)
                0: if (!rqgt_oe_n) begin
                    reqs++; chk_req = 1; arb_st = 1; arb_gap = 2; ten_bytes = 0;
                end
                1: begin
                    if (chk_req) begin
                        chk(rqgt_oe_n, "R2", "request pulse width", rqgt_oe_n, 1);
                        chk_req = 0;
                    end
                    chk(!bus_oe, "R2", "no drive before grant", bus_oe, 0);
                    if (arb_gap == 0) begin
                        pull_n = 1'b0; grant_cyc = cyc + 1; arb_st = 2;
                    end else arb_gap--;
                end
                default: if (!rqgt_oe_n) begin
                    rels++;
                    chk(!prev_oe && prev2_oe, "R4", "drop clock before release",
                        {prev2_oe, prev_oe}, 2);
                    if (c_mode == 0) chk(ten_bytes == 1, "R8", "bytes per tenure", ten_bytes, 1);
                    if (c_mode == 1) chk(ten_bytes >= 1 && ten_bytes <= c_k, "R9",
                                         "bytes per tenure", ten_bytes, c_k);
                    if (c_mode == 2) chk(ten_bytes == c_cnt, "R10", "bytes per tenure",
                                         ten_bytes, c_cnt);
                    last_rel_cyc = cyc; arb_st = 0;
                end
            endcase
            if (bus_oe && !prev_oe)
                chk(cyc - grant_cyc == c_dly, "R3", "float delay", cyc - grant_cyc, c_dly);
            if (rd_stb || wr_stb) chk(bus_oe, "R4", "strobe without bus", bus_oe, 1);
            ea = c_src + 16'(exp_idx);
            if (rd_stb && wr_stb) begin
                chk(c_fly == 1, "R6", "fly-by strobes in two-step run", c_fly, 1);
                chk(bus_addr == ea, "R7", "fly-by address", bus_addr, ea);
                exp_idx++; ten_bytes++;
            end else if (rd_stb) begin
                chk(c_fly == 0, "R6", "lone read in fly-by run", c_fly, 0);
                chk(bus_addr == ea, "R7", "read address", bus_addr, ea);
            end else if (wr_stb) begin
                chk(prev_rd, "R5", "write follows read", prev_rd, 1);
                chk(bus_addr == c_dst + 16'(exp_idx), "R7", "write address",
                    bus_addr, c_dst + 16'(exp_idx));
                chk(wr_data == (ea[7:0] ^ 8'hA5), "R5", "write data",
                    wr_data, ea[7:0] ^ 8'hA5);
                exp_idx++; ten_bytes++;
            end
            if (rdy_timer > 0) begin
                rdy_timer--;
                if (rdy_timer == 0) periph_rdy = 1'b1;
            end
            if (wr_stb) begin
                if (c_mode == 1 && ten_bytes == c_k) begin periph_rdy = 1'b0; rdy_timer = 6; end
                if (c_mode == 2 && exp_idx == 2) begin periph_rdy = 1'b0; rdy_timer = 5; end
            end
            if (done && !done_prev && c_cnt > 0)
                chk(last_rel_cyc == cyc - 1, "R11", "done after final release",
                    cyc - last_rel_cyc, 1);
            prev2_oe = prev_oe; prev_oe = bus_oe; prev_rd = rd_stb && !wr_stb;
            done_prev = done;
        end
    end

    task automatic run_case(input int md, input int fl, input int dl, input int cnt,
                            input logic [15:0] s, input logic [15:0] d);
        int exp_req;
        @(negedge clk);
        c_mode = (md == 3) ? 2 : md; c_fly = fl; c_dly = dl; c_cnt = cnt;
        c_src = s; c_dst = d;
        reqs = 0; rels = 0; exp_idx = 0;
        mode_sel = 2'(md); flyby = fl[0]; float_dly = 4'(dl);
        byte_count = 8'(cnt); src_addr = s; dst_addr = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!done, "R11", "done cleared by start", done, 0);
        repeat (2) @(negedge clk);
        src_addr = 16'hDEAD; dst_addr = 16'hBEEF; byte_count = 8'd1; start = 1'b1;
        @(negedge clk);
        start = 1'b0; src_addr = s; dst_addr = d; byte_count = 8'(cnt);
        chk(!done, "R12", "start ignored while busy", done, 0);
        while (!done) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(exp_idx == cnt, "R7", "bytes moved", exp_idx, cnt);
        exp_req = (c_mode == 0) ? cnt : (c_mode == 1) ? (cnt + c_k - 1) / c_k : 1;
        chk(reqs == exp_req, (c_mode == 0) ? "R8" : (c_mode == 1) ? "R9" : "R10",
            "request count", reqs, exp_req);
        chk(rels == reqs, "R4", "one release per request", rels, reqs);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(rqgt_oe_n && !bus_oe && !rd_stb && !wr_stb && !done, "R1", "reset state",
            {rqgt_oe_n, bus_oe, rd_stb, wr_stb, done}, 16);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        for (int md = 0; md < 3; md++)
            for (int fl = 0; fl < 2; fl++)
                for (int di = 0; di < 3; di++)
                    run_case(md, fl, (di == 2) ? 3 : di, 5 + md,
                             16'h1000 + 16'(md * 256 + fl * 64 + di),
                             16'h8000 + 16'(md * 256 + fl * 64 + di));
        run_case(3, 0, 1, 4, 16'hFFFE, 16'h00FE);
        run_case(1, 1, 2, 7, 16'h2222, 16'h3333);
        // R11: zero count finishes at once without a request
        @(negedge clk);
        c_cnt = 0; reqs = 0; byte_count = 8'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done, "R11", "zero count done", done, 1);
        repeat (4) @(negedge clk);
        chk(reqs == 0, "R2", "no request for zero count", reqs, 0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule